// File: doc/BRIEF.md
# Bus Clock Mode Controller

This block picks where the bus clock of a small microcontroller comes from and how far it is divided, and it sequences the processor's halt and power-down states. Software writes a seven-bit control word that enables the sub oscillator, stops the main oscillator, selects the clock source, forces a divide-by-8 ratio, and sets a two-bit divider select. One bit of the same word requests stop mode. A strobe from the WAIT instruction and an interrupt input drive the halt states. The clock itself is not produced here. The block emits a one-cycle enable pulse on the reference clock for each bus clock edge.

Control changes are screened against the oscillator state. A write that would run the bus from an oscillator that is not running and stable is dropped whole and raises a sticky error flag. Ratio changes that are accepted wait for the end of the bus period in progress, so no short bus clock period is ever produced. When a single write changes both the divider select and the divide-by-8 force, the divider select is applied at one period boundary and the force bit at the next. The sub clock is modelled as one bus pulse every `SUB_PERIOD` reference cycles. Oscillator stability arrives on two ready inputs.

Top module: `clk_mode_ctrl`

## Requirements
- R1: Reset state, released by rstN. Divide-by-8 from the main clock (mode code 3). Main oscillator on, sub oscillator off, CPU not halted, error flag clear, and one busClkEn pulse every 8 cycles.
- R2: Control word bits: bit0 sub-oscillator enable, bit1 main-oscillator stop, bit2 source select (1 = sub), bit3 divide-by-8 force, bits5:4 divider select, bit6 stop request. With select and force at 0, divider select 00/01/10/11 gives a pulse period of 1/2/4/16 cycles and mode codes 0/1/2/4.
- R3: With the force bit at 1 and select at 0, the period is 8 cycles and the mode code is 3, whatever the divider select holds.
- R4: When one write changes both the divider select and the force bit, the divider select is applied at the first period boundary and the force bit at the second. Leaving divide-by-8 for divide-by-2 therefore gives periods of 8, 8 and then 2.
- R5: An accepted ratio change takes effect only when the current bus period ends. The period in progress keeps its old length.
- R6: Selecting the sub clock is accepted only while the sub oscillator is enabled and its ready input is high. Once accepted, the period is SUB_PERIOD and the mode code is 5.
- R7: Setting the main-oscillator stop bit is accepted only when the sub clock is selected and stays selected. It turns mainOscOn off and gives mode code 6. Returning to the main clock is accepted only while the main oscillator is on and ready.
- R8: A rejected write changes no control bit and sets illegalErr. illegalErr stays set through later accepted writes and is cleared only by reset.
- R9: A waitStrobe pulse sets cpuHalt and leaves both oscillator enables and the bus pulses unchanged. An interrupt clears cpuHalt, and the mode is unchanged.
- R10: A write with bit6 set enters stop mode. cpuHalt goes high, both oscillator enables go low and the bus pulses stop. An interrupt re-enables the oscillators. Pulses resume only after the ready input of the selected source is high, and the mode is the one held before stop.
- R11: A stop-request write applies none of its other bits and never sets illegalErr.
- R12: Control writes while halted (wait or stop) are ignored without error. An interrupt while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 7 | Control word (bit map in R2) |
| waitStrobe | input | 1 | WAIT instruction executed |
| irq | input | 1 | Interrupt request, wakes wait or stop |
| mainReady | input | 1 | Main oscillator stable |
| subReady | input | 1 | Sub oscillator stable |
| busClkEn | output | 1 | One-cycle pulse per bus clock edge |
| modeCode | output | 3 | Current clock mode code |
| mainOscOn | output | 1 | Main oscillator enable |
| subOscOn | output | 1 | Sub oscillator enable |
| cpuHalt | output | 1 | CPU halted (wait, stop or waking) |
| illegalErr | output | 1 | Sticky rejected-write flag |

## Verification
The bench sets `SUB_PERIOD` to 5, against a default of 32. This makes the sub-clock period odd and shorter than the longest main-clock ratio, so a counter that ignored the source select, or truncated the ratio to a power of two, would show up as a wrong interval. The ready inputs come from bench counters with a 12-cycle settling delay. That delay is long enough to see selections rejected before the oscillator settles and accepted after, and to see the stop-mode wake hold the bus gated.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  localparam int WR_W    = 7;
  localparam int B_SUBEN = 0;
  localparam int B_MSTOP = 1;
  localparam int B_SEL   = 2;
  localparam int B_DIV8  = 3;
  localparam int B_DSEL  = 4;
  localparam int B_STOP  = 6;

  localparam logic [2:0] MODE_HI   = 3'd0;
  localparam logic [2:0] MODE_D2   = 3'd1;
  localparam logic [2:0] MODE_D4   = 3'd2;
  localparam logic [2:0] MODE_D8   = 3'd3;
  localparam logic [2:0] MODE_D16  = 3'd4;
  localparam logic [2:0] MODE_SUB  = 3'd5;
  localparam logic [2:0] MODE_LPWR = 3'd6;

  typedef enum logic [1:0] {PWR_RUN, PWR_WAIT, PWR_STOP, PWR_WAKE} pwr_e;

  // strobes and requested setting from control to datapath
  typedef struct packed {
    logic       hold;
    logic       gateOpen;
    logic       useSub;
    logic       div8;
    logic [1:0] divSel;
  } dpCmd_t;

  // setting currently applied by the datapath
  typedef struct packed {
    logic       useSub;
    logic       div8;
    logic [1:0] divSel;
  } dpStat_t;

endpackage

// File: rtl/cmc_div.sv
module cmc_div
  import cmc_pkg::*;
#(
  parameter int SUB_PERIOD = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCmd_t  cmd,
  output dpStat_t stat,
  output logic    busClkEn
);

  localparam int MAXR  = (SUB_PERIOD > 16) ? SUB_PERIOD : 16;
  localparam int CNT_W = $clog2(MAXR + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio;
  logic             tick;
  logic             useSubA;
  logic             div8A;
  logic [1:0]       divSelA;

  always_comb begin
    if (useSubA)    ratio = CNT_W'(SUB_PERIOD);
    else if (div8A) ratio = CNT_W'(8);
    else begin
      case (divSelA)
        2'b00:   ratio = CNT_W'(1);
        2'b01:   ratio = CNT_W'(2);
        2'b10:   ratio = CNT_W'(4);
        default: ratio = CNT_W'(16);
      endcase
    end
  end

  assign tick = (cnt == ratio - CNT_W'(1)) && !cmd.hold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      useSubA  <= 1'b0;
      div8A    <= 1'b1;
      divSelA  <= 2'b00;
      busClkEn <= 1'b0;
    end else begin
      busClkEn <= tick && cmd.gateOpen;
      if (cmd.hold) begin
        cnt <= '0;
      end else if (tick) begin
        cnt     <= '0;
        useSubA <= cmd.useSub;
        divSelA <= cmd.divSel;
        // force bit waits until the divider select already matches
        if (cmd.divSel == divSelA) div8A <= cmd.div8;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign stat = '{useSub: useSubA, div8: div8A, divSel: divSelA};

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !($stable(divSelA) && $stable(div8A) && $stable(useSubA)) |-> (cnt == '0)); // R5
  AST_DIV8_AFTER_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(div8A) |-> $stable(divSelA)); // R4
  AST_HOLD_NO_CLK: assert property (@(posedge clk) disable iff (!rstN)
    cmd.hold |=> !busClkEn); // R10

endmodule

// File: rtl/cmc_ctrl.sv
module cmc_ctrl
  import cmc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [WR_W-1:0] wrData,
  input  logic            waitStrobe,
  input  logic            irq,
  input  logic            mainReady,
  input  logic            subReady,
  input  dpStat_t         stat,
  output dpCmd_t          cmd,
  output logic [2:0]      modeCode,
  output logic            mainOscOn,
  output logic            subOscOn,
  output logic            cpuHalt,
  output logic            illegalErr
);

  pwr_e       pwrQ, pwrNext;
  logic       subEnQ, mainStopQ, selQ, div8Q;
  logic [1:0] divSelQ;
  logic       errQ;
  logic       wrLive, illegal, applyWr, selReady;
  logic       wrSub, wrMStop, wrSel, wrStop;

  assign wrSub   = wrData[B_SUBEN];
  assign wrMStop = wrData[B_MSTOP];
  assign wrSel   = wrData[B_SEL];
  assign wrStop  = wrData[B_STOP];

  assign mainOscOn = !mainStopQ && (pwrQ != PWR_STOP);
  assign subOscOn  = subEnQ && (pwrQ != PWR_STOP);
  assign cpuHalt   = (pwrQ != PWR_RUN);
  assign illegalErr = errQ;

  assign wrLive  = wrEn && (pwrQ == PWR_RUN) && !wrStop;
  assign illegal = (wrSel && !selQ && !(subOscOn && subReady))
                || (!wrSel && selQ && !(mainOscOn && mainReady))
                || (wrMStop && !(selQ && wrSel))
                || (!wrSub && (wrSel || stat.useSub));
  assign applyWr = wrLive && !illegal;

  assign selReady = stat.useSub ? subReady : mainReady;

  always_comb begin
    pwrNext = pwrQ;
    case (pwrQ)
      PWR_RUN:  if (wrEn && wrStop) pwrNext = PWR_STOP;
                else if (waitStrobe) pwrNext = PWR_WAIT;
      PWR_WAIT: if (irq) pwrNext = PWR_RUN;
      PWR_STOP: if (irq) pwrNext = PWR_WAKE;
      PWR_WAKE: if (selReady) pwrNext = PWR_RUN;
      default:  pwrNext = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrQ      <= PWR_RUN;
      subEnQ    <= 1'b0;
      mainStopQ <= 1'b0;
      selQ      <= 1'b0;
      div8Q     <= 1'b1;
      divSelQ   <= 2'b00;
      errQ      <= 1'b0;
    end else begin
      pwrQ <= pwrNext;
      if (applyWr) begin
        subEnQ    <= wrSub;
        mainStopQ <= wrMStop;
        selQ      <= wrSel;
        div8Q     <= wrData[B_DIV8];
        divSelQ   <= wrData[B_DSEL +: 2];
      end
      if (wrLive && illegal) errQ <= 1'b1;
    end
  end

  assign cmd = '{hold:     (pwrQ == PWR_STOP) || (pwrQ == PWR_WAKE),
                 gateOpen: (pwrQ == PWR_RUN) || (pwrQ == PWR_WAIT),
                 useSub:   selQ,
                 div8:     div8Q,
                 divSel:   divSelQ};

  always_comb begin
    if (stat.useSub)    modeCode = mainStopQ ? MODE_LPWR : MODE_SUB;
    else if (stat.div8) modeCode = MODE_D8;
    else begin
      case (stat.divSel)
        2'b00:   modeCode = MODE_HI;
        2'b01:   modeCode = MODE_D2;
        2'b10:   modeCode = MODE_D4;
        default: modeCode = MODE_D16;
      endcase
    end
  end

  AST_SUB_SEL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selQ) |-> $past(subOscOn && subReady)); // R6
  AST_MAIN_STOP_ON_SUB: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainStopQ) |-> ($past(selQ) && selQ)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ); // R8
  AST_STOP_NOT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (pwrQ == PWR_STOP) |=> (pwrQ != PWR_RUN)); // R10
  AST_HALT_FREEZES_CFG: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt |=> ($stable(div8Q) && $stable(divSelQ) && $stable(selQ))); // R12

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int SUB_PERIOD = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [WR_W-1:0] wrData,
  input  logic            waitStrobe,
  input  logic            irq,
  input  logic            mainReady,
  input  logic            subReady,
  output logic            busClkEn,
  output logic [2:0]      modeCode,
  output logic            mainOscOn,
  output logic            subOscOn,
  output logic            cpuHalt,
  output logic            illegalErr
);

  dpCmd_t  cmd;
  dpStat_t stat;

  cmc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .waitStrobe(waitStrobe), .irq(irq),
    .mainReady(mainReady), .subReady(subReady),
    .stat(stat), .cmd(cmd), .modeCode(modeCode),
    .mainOscOn(mainOscOn), .subOscOn(subOscOn),
    .cpuHalt(cpuHalt), .illegalErr(illegalErr)
  );

  cmc_div #(.SUB_PERIOD(SUB_PERIOD)) u_div (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stat(stat), .busClkEn(busClkEn)
  );

endmodule

// File: tb/clk_mode_ctrl_bench.sv
module clk_mode_ctrl_bench;

  localparam int SUBP      = 5;
  localparam int READY_DLY = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [6:0] wrData = '0;
  logic       waitStrobe = 1'b0;
  logic       irq = 1'b0;
  logic       mainReady, subReady;
  logic       busClkEn, mainOscOn, subOscOn, cpuHalt, illegalErr;
  logic [2:0] modeCode;

  int nChk = 0;
  int nFail = 0;
  int cycles = 0;
  int mCnt = 0;
  int sCnt = 0;

  always #5 clk = ~clk;

  clk_mode_ctrl #(.SUB_PERIOD(SUBP)) u_clk_mode_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .waitStrobe(waitStrobe), .irq(irq),
    .mainReady(mainReady), .subReady(subReady),
    .busClkEn(busClkEn), .modeCode(modeCode),
    .mainOscOn(mainOscOn), .subOscOn(subOscOn),
    .cpuHalt(cpuHalt), .illegalErr(illegalErr)
  );

  // oscillator settling models
  always_ff @(posedge clk) begin
    if (!rstN || !mainOscOn) mCnt <= 0;
    else if (mCnt < READY_DLY) mCnt <= mCnt + 1;
    if (!rstN || !subOscOn) sCnt <= 0;
    else if (sCnt < READY_DLY) sCnt <= sCnt + 1;
  end
  assign mainReady = (mCnt == READY_DLY);
  assign subReady  = (sCnt == READY_DLY);

  // stimulus table: divSel, div8 force, expected period
  localparam logic [7:0] VEC [8] = '{
    {2'b00, 1'b0, 5'd1},  {2'b01, 1'b0, 5'd2},
    {2'b10, 1'b0, 5'd4},  {2'b11, 1'b0, 5'd16},
    {2'b00, 1'b1, 5'd8},  {2'b11, 1'b1, 5'd8},
    {2'b01, 1'b1, 5'd8},  {2'b10, 1'b0, 5'd4}
  };

  function automatic logic [6:0] mk(input logic stp, input logic [1:0] ds,
      input logic d8, input logic sel, input logic ms, input logic se);
    return {stp, ds, d8, sel, ms, se};
  endfunction

  function automatic int expMode(input logic [1:0] ds, input logic d8);
    if (d8) return 3;
    case (ds)
      2'b00: return 0;
      2'b01: return 1;
      2'b10: return 2;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  // cycles (negedges) until the next bus pulse
  task automatic pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!busClkEn && n < 200);
    if (n >= 200) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected below 200 cycles without pulse", n);
      finishRun();
    end
  endtask

  task automatic period(output int p);
    int dummy;
    pulse(dummy);
    pulse(p);
  endtask

  task automatic settle();
    int d;
    for (int i = 0; i < 3; i++) pulse(d);
  endtask

  task automatic wr(input logic [6:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected fewer cycles", cycles);
      finishRun();
    end
  end

  initial begin
    int p, n, cnt;
    @(negedge clk);
    doReset();

    // R1 reset state
    chk("R1 mode", modeCode, 3);
    chk("R1 mainOscOn", mainOscOn, 1);
    chk("R1 subOscOn", subOscOn, 0);
    chk("R1 cpuHalt", cpuHalt, 0);
    chk("R1 illegalErr", illegalErr, 0);
    period(p);
    chk("R1 period", p, 8);

    // R4 divider select first, force bit one boundary later
    pulse(n);
    wr(mk(0, 2'b01, 0, 0, 0, 0));
    pulse(n);
    chk("R4 first period", n + 1, 8);
    pulse(n);
    chk("R4 second period still /8", n, 8);
    pulse(n);
    chk("R4 third period /2", n, 2);

    // R2 R3 table walk
    for (int i = 0; i < 8; i++) begin
      wr(mk(0, VEC[i][7:6], VEC[i][5], 0, 0, 0));
      settle();
      period(p);
      chk(VEC[i][5] ? "R3 period" : "R2 period", p, int'(VEC[i][4:0]));
      chk(VEC[i][5] ? "R3 mode" : "R2 mode", modeCode, expMode(VEC[i][7:6], VEC[i][5]));
    end

    // R5 period in progress keeps old length
    wr(mk(0, 2'b11, 0, 0, 0, 0));
    settle();
    pulse(n);
    wr(mk(0, 2'b00, 0, 0, 0, 0));
    pulse(n);
    chk("R5 old period kept", n + 1, 16);
    pulse(n);
    chk("R5 new period", n, 1);

    // R7 R8 main stop while on main clock rejected
    wr(mk(0, 2'b00, 0, 0, 1, 0));
    chk("R7 main stays on", mainOscOn, 1);
    chk("R8 error set", illegalErr, 1);
    // R6 select sub before stable rejected
    wr(mk(0, 2'b00, 0, 1, 0, 1));
    chk("R6 sub not enabled", subOscOn, 0);
    settle();
    chk("R6 mode unchanged", modeCode, 0);
    // R6 enable, settle, select
    wr(mk(0, 2'b00, 0, 0, 0, 1));
    chk("R6 sub enabled", subOscOn, 1);
    idle(READY_DLY + 3);
    wr(mk(0, 2'b00, 0, 1, 0, 1));
    settle();
    period(p);
    chk("R6 sub period", p, SUBP);
    chk("R6 sub mode", modeCode, 5);
    chk("R8 error sticky", illegalErr, 1);

    // R7 low power dissipation
    wr(mk(0, 2'b00, 0, 1, 1, 1));
    chk("R7 main stopped", mainOscOn, 0);
    chk("R7 lowpower mode", modeCode, 6);
    wr(mk(0, 2'b00, 0, 0, 0, 1));
    settle();
    chk("R7 back to main rejected", modeCode, 6);
    chk("R7 main still off", mainOscOn, 0);
    wr(mk(0, 2'b00, 0, 1, 0, 1));
    chk("R7 main restarted", mainOscOn, 1);
    idle(READY_DLY + 3);
    wr(mk(0, 2'b00, 0, 0, 0, 1));
    settle();
    period(p);
    chk("R7 main period", p, 1);
    chk("R7 main mode", modeCode, 0);

    // R9 wait mode
    waitStrobe = 1'b1;
    @(negedge clk);
    waitStrobe = 1'b0;
    chk("R9 halted", cpuHalt, 1);
    chk("R9 main on", mainOscOn, 1);
    chk("R9 sub on", subOscOn, 1);
    period(p);
    chk("R9 pulses continue", p, 1);
    // R12 write while halted ignored
    wr(mk(0, 2'b11, 0, 0, 0, 1));
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    chk("R9 released", cpuHalt, 0);
    settle();
    period(p);
    chk("R12 halted write ignored", p, 1);
    chk("R9 mode kept", modeCode, 0);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    idle(2);
    chk("R12 irq in run", cpuHalt, 0);
    chk("R12 irq in run mode", modeCode, 0);

    // R10 R11 stop mode from fresh reset
    doReset();
    chk("R8 cleared by reset", illegalErr, 0);
    settle();
    wr(mk(1, 2'b11, 0, 1, 1, 1));
    chk("R10 halted", cpuHalt, 1);
    chk("R10 main off", mainOscOn, 0);
    chk("R10 sub off", subOscOn, 0);
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busClkEn) cnt++;
    end
    chk("R10 no pulses", cnt, 0);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    chk("R10 main restarted", mainOscOn, 1);
    pulse(n);
    chk("R10 gated until ready", int'(n > READY_DLY), 1);
    chk("R10 running", cpuHalt, 0);
    period(p);
    chk("R11 other bits ignored", p, 8);
    chk("R10 mode kept", modeCode, 3);
    chk("R11 no error", illegalErr, 0);
    chk("R11 sub stays off", subOscOn, 0);

    finishRun();
  end

endmodule